// File: doc/BRIEF.md
# Tamper Monitor Security State Machine

This block keeps the security condition of an always-on tamper monitor. Up to ten tamper and violation event lines come in from the sensors. Each line leaves a sticky bit in a status vector. A line whose bit is set in the tamper configuration register also pushes the unit into failure by raising the violation flag. The condition is the pair of a non-valid flag and a violation flag, and a pair of 00 means valid. While either flag is up, the time counter is held, so the moment of the event is kept.

Two resets act on the block. The battery-domain reset (`bat_rst_n`) is asynchronous and active low, and it is released synchronously. It clears every register and leaves the unit in non-valid. The system power-on request (`sys_por_n`) is a synchronous active-low level. It wipes the soft lock bits, and it moves a unit that is in failure to the combined non-valid plus failure condition. Only from that combined condition can software recover, and only in a fixed order. First the sticky event bits are cleared, then the violation flag, and last the non-valid flag. All three are cleared by writing 1s.

Lock bits can only be set by software. Hard locks survive a system power-on, and soft locks do not. The lock bits guard the configuration register, the permission to load the time counter, and recovery from failure.

Top module: `tamper_guard`

## Requirements
- R1: While `bat_rst_n` is low, and after it is released, `nvf_o`=1, `svf_o`=0, and `evt_status_o`, `cfg_o` and `lock_o` are all zero.
- R2: A high `evt_i[i]` sets `evt_status_o[i]` on the next clock edge whether or not `cfg_o[i]` is set. The event order is: 0 voltage, 1 clock, 2 temperature, 3 secure-controller alarm, 4 external boot, 5 external A, 6 external B, 7 wire mesh, 8 timer-counter overflow, 9 monotonic-counter overflow.
- R3: A high `evt_i[i]` with `cfg_o[i]`=1 sets `svf_o` on the next edge. A disabled event leaves `svf_o` unchanged.
- R4: In failure without non-valid (`svf_o`=1, `nvf_o`=0), clear writes to event bits or to the violation flag have no effect. A low `sys_por_n` sets `nvf_o` on the next edge while `svf_o` stays 1.
- R5: A clear write (`clr_we_i`=1) uses bits [N-1:0] of `clr_wdata_i` for the event bits, bit N for the violation flag and bit N+1 for the non-valid flag. Event bits written with 1 clear whenever the unit is not in failure-only. A new event on the same edge wins.
- R6: `svf_o` clears only when the write happens while `nvf_o`=1 and `evt_status_o` is already all zero. `nvf_o` clears only when the write happens while `svf_o`=0. So a single write that clears both the event bits and the violation flag leaves `svf_o` set.
- R7: `cfg_we_i` loads `cfg_wdata_i` into `cfg_o` only while lock bits 0 (configuration hard) and 1 (configuration soft) are both clear.
- R8: `lock_we_i` ORs `lock_wdata_i` into `lock_o`, so writing 0 never clears a bit. A low `sys_por_n` clears soft bits 1 and 3 (timer soft) and keeps hard bits 0, 2 (timer hard) and 4 (failure hard). Only `bat_rst_n` clears hard bits.
- R9: With lock bit 4 set, `svf_o` cannot be cleared by any write.
- R10: `tc_stop_o` is high exactly when `svf_o` or `nvf_o` is high. `tc_wr_ok_o` is high exactly when `svf_o`=0 and lock bits 2 and 3 are clear.
- R11: `viol_irq_o` is high exactly when `svf_o`=1 and `viol_ie_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bat_rst_n | input | 1 | Battery-domain reset, asynchronous, active low |
| sys_por_n | input | 1 | System power-on request, synchronous, active low |
| evt_i | input | N | Tamper and violation event lines |
| cfg_we_i | input | 1 | Write strobe for the tamper configuration register |
| cfg_wdata_i | input | N | Per-event enable bits to write |
| lock_we_i | input | 1 | Write strobe that sets lock bits |
| lock_wdata_i | input | 5 | Lock bits to set |
| clr_we_i | input | 1 | Write-one-to-clear strobe for status and flags |
| clr_wdata_i | input | N+2 | Clear mask: events, violation flag, non-valid flag |
| viol_ie_i | input | 1 | Violation interrupt enable |
| cfg_o | output | N | Tamper configuration register |
| lock_o | output | 5 | Lock bits |
| evt_status_o | output | N | Sticky event status |
| nvf_o | output | 1 | Non-valid flag |
| svf_o | output | 1 | Security-violation flag |
| tc_stop_o | output | 1 | Hold request for the time counter |
| tc_wr_ok_o | output | 1 | Time counter may be loaded |
| viol_irq_o | output | 1 | Security-violation interrupt |

## Verification
The properties assume that `sys_por_n` and all write strobes are synchronous to `clk` and stable around each rising edge. They also assume that events are sampled only as levels at the edge, with no meaning between edges. The bench changes every input a few nanoseconds after a rising edge and holds it for one full cycle. It keeps `bat_rst_n` low for several edges, so the reset synchronizer is always flushed before any check is made.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int LOCK_W       = 5;
  localparam int LK_CFG_HARD  = 0;
  localparam int LK_CFG_SOFT  = 1;
  localparam int LK_TMR_HARD  = 2;
  localparam int LK_TMR_SOFT  = 3;
  localparam int LK_FAIL_HARD = 4;
  // bits cleared by a system power-on request
  localparam logic [LOCK_W-1:0] LOCK_SOFT_MASK = 5'b01010;

  typedef enum logic [1:0] {
    ST_VALID    = 2'b00,
    ST_FAIL     = 2'b01,
    ST_NONVALID = 2'b10,
    ST_NV_FAIL  = 2'b11
  } tg_cond_e;
endpackage

// File: rtl/tg_cfg_lock.sv
module tg_cfg_lock
  import tg_pkg::*;
#(
  parameter int N = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_por_n,
  input  logic              cfg_we,
  input  logic [N-1:0]      cfg_wdata,
  input  logic              lock_we,
  input  logic [LOCK_W-1:0] lock_wdata,
  output logic [N-1:0]      cfg_q,
  output logic [LOCK_W-1:0] lock_q
);
  logic [N-1:0]      cfg_d;
  logic              cfg_en;
  logic [LOCK_W-1:0] lock_d;

  assign cfg_en = cfg_we && !lock_q[LK_CFG_HARD] && !lock_q[LK_CFG_SOFT];

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_en) cfg_d = cfg_wdata;
  end

  for (genvar b = 0; b < LOCK_W; b++) begin : g_lock
    if (LOCK_SOFT_MASK[b]) begin : g_soft
      always_comb begin
        lock_d[b] = lock_q[b] | (lock_we & lock_wdata[b]);
        if (!sys_por_n) lock_d[b] = 1'b0;
      end
    end else begin : g_hard
      always_comb lock_d[b] = lock_q[b] | (lock_we & lock_wdata[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      lock_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
    end
  end
endmodule

// File: rtl/tg_evt_status.sv
module tg_evt_status #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] cfg,
  input  logic         clr_en,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] status_q,
  output logic         fail_hit,
  output logic         status_zero
);
  logic [N-1:0] status_d;

  always_comb begin
    status_d = status_q;
    if (clr_en) status_d = status_d & ~clr_mask;
    status_d = status_d | evt;
  end

  assign fail_hit    = |(evt & cfg);
  assign status_zero = (status_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/tg_state_fsm.sv
module tg_state_fsm
  import tg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sys_por_n,
  input  logic fail_hit,
  input  logic clr_svf_req,
  input  logic clr_nvf_req,
  input  logic status_zero,
  input  logic fail_hard,
  output logic nvf_q,
  output logic svf_q
);
  tg_cond_e cond_q, cond_d;

  assign nvf_q = cond_q[1];
  assign svf_q = cond_q[0];

  always_comb begin
    logic n_d, s_d;
    n_d = nvf_q;
    s_d = svf_q;
    case (cond_q)
      ST_FAIL: begin
        if (!sys_por_n) n_d = 1'b1;
      end
      ST_NV_FAIL: begin
        if (clr_svf_req && status_zero && !fail_hard) s_d = 1'b0;
      end
      ST_NONVALID: begin
        if (clr_nvf_req) n_d = 1'b0;
      end
      default: ;
    endcase
    if (fail_hit) s_d = 1'b1;
    cond_d = tg_cond_e'({n_d, s_d});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= ST_NONVALID;
    else        cond_q <= cond_d;
  end
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
  import tg_pkg::*;
#(
  parameter int N = 10
) (
  input  logic              clk,
  input  logic              bat_rst_n,
  input  logic              sys_por_n,
  input  logic [N-1:0]      evt_i,
  input  logic              cfg_we_i,
  input  logic [N-1:0]      cfg_wdata_i,
  input  logic              lock_we_i,
  input  logic [LOCK_W-1:0] lock_wdata_i,
  input  logic              clr_we_i,
  input  logic [N+1:0]      clr_wdata_i,
  input  logic              viol_ie_i,
  output logic [N-1:0]      cfg_o,
  output logic [LOCK_W-1:0] lock_o,
  output logic [N-1:0]      evt_status_o,
  output logic              nvf_o,
  output logic              svf_o,
  output logic              tc_stop_o,
  output logic              tc_wr_ok_o,
  output logic              viol_irq_o
);
  localparam int SVF_BIT = N;
  localparam int NVF_BIT = N + 1;

  logic [1:0] rst_pipe_q;
  logic       rst_n_q;
  logic       fail_hit;
  logic       status_zero;
  logic       evt_clr_en;

  always_ff @(posedge clk or negedge bat_rst_n) begin
    if (!bat_rst_n) rst_pipe_q <= 2'b00;
    else            rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_q = rst_pipe_q[1];

  // event bits may be cleared anywhere except failure-only
  assign evt_clr_en = clr_we_i && (nvf_o || !svf_o);

  tg_cfg_lock #(.N(N)) u_cfg_lock (
    .clk        (clk),
    .rst_n      (rst_n_q),
    .sys_por_n  (sys_por_n),
    .cfg_we     (cfg_we_i),
    .cfg_wdata  (cfg_wdata_i),
    .lock_we    (lock_we_i),
    .lock_wdata (lock_wdata_i),
    .cfg_q      (cfg_o),
    .lock_q     (lock_o)
  );

  tg_evt_status #(.N(N)) u_evt (
    .clk         (clk),
    .rst_n       (rst_n_q),
    .evt         (evt_i),
    .cfg         (cfg_o),
    .clr_en      (evt_clr_en),
    .clr_mask    (clr_wdata_i[N-1:0]),
    .status_q    (evt_status_o),
    .fail_hit    (fail_hit),
    .status_zero (status_zero)
  );

  tg_state_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_q),
    .sys_por_n   (sys_por_n),
    .fail_hit    (fail_hit),
    .clr_svf_req (clr_we_i && clr_wdata_i[SVF_BIT]),
    .clr_nvf_req (clr_we_i && clr_wdata_i[NVF_BIT]),
    .status_zero (status_zero),
    .fail_hard   (lock_o[LK_FAIL_HARD]),
    .nvf_q       (nvf_o),
    .svf_q       (svf_o)
  );

  assign tc_stop_o  = svf_o | nvf_o;
  assign tc_wr_ok_o = !svf_o && !lock_o[LK_TMR_HARD] && !lock_o[LK_TMR_SOFT];
  assign viol_irq_o = svf_o & viol_ie_i;
endmodule

// File: rtl/tg_checker.sv
module tg_checker
  import tg_pkg::*;
#(
  parameter int N = 10
) (
  input logic              clk,
  input logic              rst_n_q,
  input logic              sys_por_n,
  input logic [N-1:0]      evt_i,
  input logic              clr_we_i,
  input logic [N+1:0]      clr_wdata_i,
  input logic              viol_ie_i,
  input logic [N-1:0]      cfg_o,
  input logic [LOCK_W-1:0] lock_o,
  input logic [N-1:0]      evt_status_o,
  input logic              nvf_o,
  input logic              svf_o,
  input logic              tc_stop_o,
  input logic              viol_irq_o
);
  assert_enabled_evt_fails_R3: assert property (@(posedge clk) disable iff (!rst_n_q)
    (|(evt_i & cfg_o)) |=> svf_o);

  assert_evt_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n_q)
    (evt_i != '0) |=> ((evt_status_o & $past(evt_i)) == $past(evt_i)));

  assert_svf_exit_order_R6: assert property (@(posedge clk) disable iff (!rst_n_q)
    $fell(svf_o) |-> ($past(nvf_o) && $past(evt_status_o) == '0 && !$past(lock_o[LK_FAIL_HARD])));

  assert_nvf_exit_R6: assert property (@(posedge clk) disable iff (!rst_n_q)
    $fell(nvf_o) |-> !$past(svf_o));

  assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n_q)
    !$stable(cfg_o) |-> (!$past(lock_o[LK_CFG_HARD]) && !$past(lock_o[LK_CFG_SOFT])));

  assert_hard_locks_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_q)
    !$fell(lock_o[LK_CFG_HARD]) && !$fell(lock_o[LK_TMR_HARD]) && !$fell(lock_o[LK_FAIL_HARD]));

  assert_soft_lock_clear_R8: assert property (@(posedge clk) disable iff (!rst_n_q)
    ($fell(lock_o[LK_CFG_SOFT]) || $fell(lock_o[LK_TMR_SOFT])) |-> !$past(sys_por_n));

  assert_fail_only_por_R4: assert property (@(posedge clk) disable iff (!rst_n_q)
    (svf_o && !nvf_o && !sys_por_n) |=> (svf_o && nvf_o));

  assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n_q)
    svf_o |-> tc_stop_o);

  assert_irq_R11: assert property (@(posedge clk) disable iff (!rst_n_q)
    viol_irq_o |-> (svf_o && viol_ie_i));
endmodule

bind tamper_guard tg_checker #(.N(N)) u_chk (
  .clk          (clk),
  .rst_n_q      (rst_n_q),
  .sys_por_n    (sys_por_n),
  .evt_i        (evt_i),
  .clr_we_i     (clr_we_i),
  .clr_wdata_i  (clr_wdata_i),
  .viol_ie_i    (viol_ie_i),
  .cfg_o        (cfg_o),
  .lock_o       (lock_o),
  .evt_status_o (evt_status_o),
  .nvf_o        (nvf_o),
  .svf_o        (svf_o),
  .tc_stop_o    (tc_stop_o),
  .viol_irq_o   (viol_irq_o)
);

// File: tb/tamper_guard_tb.sv
`timescale 1ns/1ps
module tamper_guard_tb;
  localparam int N  = 10;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          bat_rst_n;
  logic          sys_por_n;
  logic [N-1:0]  evt_i;
  logic          cfg_we_i;
  logic [N-1:0]  cfg_wdata_i;
  logic          lock_we_i;
  logic [LW-1:0] lock_wdata_i;
  logic          clr_we_i;
  logic [N+1:0]  clr_wdata_i;
  logic          viol_ie_i;
  logic [N-1:0]  cfg_o;
  logic [LW-1:0] lock_o;
  logic [N-1:0]  evt_status_o;
  logic          nvf_o, svf_o, tc_stop_o, tc_wr_ok_o, viol_irq_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  tamper_guard #(.N(N)) u_dut (
    .clk(clk), .bat_rst_n(bat_rst_n), .sys_por_n(sys_por_n), .evt_i(evt_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .lock_we_i(lock_we_i),
    .lock_wdata_i(lock_wdata_i), .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
    .viol_ie_i(viol_ie_i), .cfg_o(cfg_o), .lock_o(lock_o),
    .evt_status_o(evt_status_o), .nvf_o(nvf_o), .svf_o(svf_o),
    .tc_stop_o(tc_stop_o), .tc_wr_ok_o(tc_wr_ok_o), .viol_irq_o(viol_irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    sys_por_n = 1; evt_i = '0; cfg_we_i = 0; cfg_wdata_i = '0;
    lock_we_i = 0; lock_wdata_i = '0; clr_we_i = 0; clr_wdata_i = '0;
  endtask

  task automatic bat_reset();
    idle();
    bat_rst_n = 0;
    tick(); tick();
    bat_rst_n = 1;
    tick(); tick(); tick();
  endtask

  task automatic clr(input logic [N+1:0] m);
    clr_we_i = 1; clr_wdata_i = m; tick(); clr_we_i = 0; clr_wdata_i = '0;
  endtask

  task automatic wcfg(input logic [N-1:0] v);
    cfg_we_i = 1; cfg_wdata_i = v; tick(); cfg_we_i = 0;
  endtask

  task automatic wlock(input logic [LW-1:0] v);
    lock_we_i = 1; lock_wdata_i = v; tick(); lock_we_i = 0; lock_wdata_i = '0;
  endtask

  task automatic por();
    sys_por_n = 0; tick(); sys_por_n = 1;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    evt_i = v; tick(); evt_i = '0;
  endtask

  localparam logic [N+1:0] CLR_SVF = (N+2)'(1) << N;
  localparam logic [N+1:0] CLR_NVF = (N+2)'(1) << (N+1);

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    viol_ie_i = 1;
    idle();
    bat_rst_n = 0;
    tick();
    check("R1 nvf in reset", nvf_o, 1);
    check("R1 svf in reset", svf_o, 0);
    bat_reset();
    check("R1 nvf", nvf_o, 1);
    check("R1 svf", svf_o, 0);
    check("R1 status", evt_status_o, 0);
    check("R1 cfg", cfg_o, 0);
    check("R1 lock", lock_o, 0);
    check("R10 stop in nonvalid", tc_stop_o, 1);

    // sweep every event with its enable off and on
    for (int i = 0; i < N; i++) begin
      for (int en = 0; en < 2; en++) begin
        logic [N-1:0] bit_i;
        bit_i = (N)'(1) << i;
        bat_reset();
        clr(CLR_NVF);
        check("R6 nvf clears in nonvalid", nvf_o, 0);
        check("R10 running when valid", tc_stop_o, 0);
        wcfg(en ? bit_i : '0);
        check("R7 cfg write", cfg_o, en ? bit_i : 0);
        pulse(bit_i);
        check("R2 sticky status", evt_status_o, bit_i);
        check("R3 svf on event", svf_o, en);
        check("R10 stop", tc_stop_o, en);
        check("R10 wr ok", tc_wr_ok_o, !en);
        check("R11 irq", viol_irq_o, en);
        if (en) begin
          clr(CLR_SVF | (N+2)'(bit_i));
          check("R4 svf kept in failure-only", svf_o, 1);
          check("R4 status kept in failure-only", evt_status_o, bit_i);
          por();
          check("R4 por sets nvf", nvf_o, 1);
          check("R4 por keeps svf", svf_o, 1);
          clr(CLR_SVF | (N+2)'(bit_i));
          check("R6 svf kept while status nonzero", svf_o, 1);
          check("R5 status cleared", evt_status_o, 0);
          clr(CLR_NVF);
          check("R6 nvf kept while svf", nvf_o, 1);
          clr(CLR_SVF);
          check("R6 svf cleared", svf_o, 0);
          check("R6 nvf still set", nvf_o, 1);
          clr(CLR_NVF);
          check("R6 back to valid", {nvf_o, svf_o}, 2'b00);
        end else begin
          clr((N+2)'(bit_i));
          check("R5 status cleared in valid", evt_status_o, 0);
        end
      end
    end

    // event and clear on the same edge: event wins
    bat_reset();
    evt_i = (N)'(1) << 3; clr_we_i = 1; clr_wdata_i = (N+2)'(1) << 3;
    tick(); idle();
    check("R5 event beats clear", evt_status_o, 10'h008);

    // configuration soft lock
    bat_reset();
    wcfg(10'h0ff);
    wlock(5'b00010);
    check("R8 soft lock set", lock_o, 5'b00010);
    wcfg(10'h001);
    check("R7 cfg held by soft lock", cfg_o, 10'h0ff);
    wlock(5'b00000);
    check("R8 zero write keeps lock", lock_o, 5'b00010);
    por();
    check("R8 por clears soft lock", lock_o, 0);
    wcfg(10'h001);
    check("R7 cfg writable again", cfg_o, 10'h001);

    // hard locks survive system power-on
    wlock(5'b10101);
    por();
    check("R8 hard locks survive por", lock_o, 5'b10101);
    wcfg(10'h3ff);
    check("R7 cfg held by hard lock", cfg_o, 10'h001);
    check("R10 timer lock blocks load", tc_wr_ok_o, 0);
    bat_reset();
    check("R8 battery reset clears hard", lock_o, 0);

    // timer soft lock
    clr(CLR_NVF);
    check("R10 load allowed", tc_wr_ok_o, 1);
    wlock(5'b01000);
    check("R10 timer soft lock", tc_wr_ok_o, 0);
    por();
    check("R10 soft timer lock gone", tc_wr_ok_o, 1);

    // failure hard lock blocks recovery
    wcfg(10'h200);
    wlock(5'b10000);
    pulse(10'h200);
    check("R3 overflow fails", svf_o, 1);
    por();
    clr((N+2)'(10'h200));
    check("R5 status cleared", evt_status_o, 0);
    clr(CLR_SVF);
    check("R9 svf held by hard lock", svf_o, 1);
    viol_ie_i = 0;
    #1;
    check("R11 irq masked", viol_irq_o, 0);
    viol_ie_i = 1;
    #1;
    check("R11 irq enabled", viol_irq_o, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule